// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four peripheral transfer requests is served next. The request lines arrive with no timing relation to the clock, so each one is brought into the clock domain through a short flop chain. Requests from channels that are switched off are masked out. The surviving requests are resolved by one of two policies, selected by an input pin that can change at run time. In fixed order the lowest-numbered channel always wins. In circular order the search begins just after the channel that was served last.

The chosen channel is offered downstream on a valid/ready handshake. `gnt_valid` rises together with a one-hot vector and a channel number. Back-pressure rule: while `gnt_ready` is low, the offer stays up and the chosen channel does not change, even if the request that caused it goes away. Once the offer is accepted, the block holds the grant and reports `xfer_busy` until the transfer engine pulses `xfer_done`. Between accept and done, no new arbitration takes place.

At completion the served channel becomes the reference point for circular order. If the transfer reached its terminal count and stop-on-terminal-count is selected, that channel's enable is cleared automatically. Software replaces the whole enable set with a one-cycle write strobe.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset no offer is made (`gnt_valid`=0, `xfer_busy`=0, `gnt_onehot`=0). All four channels are disabled, and the circular pointer behaves as if channel 3 was served last.
- R2: A request line passes through two synchroniser flops before arbitration. A request that is set while the block is idle is offered after exactly three rising clock edges, and not after two.
- R3: A request on a channel whose enable bit is 0 is never offered. If no enabled channel requests, `gnt_valid` stays 0.
- R4: With `rot_mode`=0, the lowest-numbered enabled requesting channel is offered (channel 0 highest, channel 3 lowest).
- R5: With `rot_mode`=1, the search starts at the channel after the one served last and wraps from 3 to 0. The channel just served therefore has the lowest priority.
- R6: The served-channel pointer is updated at every completed transfer, in either mode.
- R7: While `gnt_valid`=1 and `gnt_ready`=0, `gnt_valid` stays 1 and `gnt_idx` does not change, even if the request is withdrawn.
- R8: After an accepted offer (`gnt_valid`&`gnt_ready`), `xfer_busy` is 1 and `gnt_valid` is 0, with `gnt_idx` unchanged, until the cycle after `xfer_done`. The block is then idle again.
- R9: When `xfer_done` comes with `xfer_tc`=1 and `tc_stop`=1, the enable bit of the served channel is cleared. With `tc_stop`=0 it is kept.
- R10: `en_we` loads `en_wdata` (bit n enables channel n) into the enables. If the write and an automatic clear fall in the same cycle, the written value wins.
- R11: `gnt_onehot` has exactly bit `gnt_idx` set while an offer or transfer is active, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous deassertion assumed |
| drq_async | input | 4 | Asynchronous transfer requests, one per channel |
| rot_mode | input | 1 | 0 = fixed order, 1 = circular order |
| tc_stop | input | 1 | 1 = disable a channel on terminal count |
| en_we | input | 1 | Enable-set write strobe |
| en_wdata | input | 4 | New enable set, bit n for channel n |
| gnt_valid | output | 1 | Offer of a channel is pending |
| gnt_ready | input | 1 | Downstream accepts the offer |
| gnt_idx | output | 2 | Number of the offered or served channel |
| gnt_onehot | output | 4 | One-hot form of the same channel |
| xfer_busy | output | 1 | Accepted transfer in progress |
| xfer_done | input | 1 | Transfer finished (one-cycle pulse while busy) |
| xfer_tc | input | 1 | Finished transfer reached terminal count |

## Verification
Directed patterns use all four requests at once. In fixed order these must always yield channel 0, and in circular order they must walk 0,1,2,3,0. This separates the two policies and exposes a wrong wrap point. Masked patterns, where only disabled channels request, show whether the enable mask is applied. Terminal-count completions with and without the stop option, and one completion that coincides with an enable write, show whether the automatic clear is applied and whether it is overridden correctly. Random request sets, enable sets and mode changes are compared against a bench-side priority model that tracks the last served channel. Every offer is also checked for the three-edge latency, for stability under withheld ready, and for the busy hold.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/drq_sync.sv
module drq_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_async,
  output logic [NCH-1:0] d_sync
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async[g]};
      end
      assign d_sync[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic [IW-1:0]  start,
  output logic           found,
  output logic [IW-1:0]  idx
);
  logic [IW:0] pos;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    // scan from lowest priority to highest so the last hit wins
    for (int k = NCH - 1; k >= 0; k--) begin
      pos = {1'b0, start} + (IW+1)'(k);
      if (pos >= (IW+1)'(NCH)) pos = pos - (IW+1)'(NCH);
      if (req[pos[IW-1:0]]) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/chan_enable.sv
module chan_enable #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_data,
  input  logic           clr_en,
  input  logic [IW-1:0]  clr_idx,
  output logic [NCH-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_en)  en_q <= wr_data;
    else if (clr_en) en_q[clr_idx] <= 1'b0;
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IW         = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] drq_async,
  input  logic           rot_mode,
  input  logic           tc_stop,
  input  logic           en_we,
  input  logic [NCH-1:0] en_wdata,
  output logic           gnt_valid,
  input  logic           gnt_ready,
  output logic [IW-1:0]  gnt_idx,
  output logic [NCH-1:0] gnt_onehot,
  output logic           xfer_busy,
  input  logic           xfer_done,
  input  logic           xfer_tc
);
  import dma_arb_pkg::*;

  arb_state_e     state_q;
  logic [IW-1:0]  grant_q;
  logic [IW-1:0]  last_q;
  logic [IW-1:0]  start;
  logic [NCH-1:0] drq_s;
  logic [NCH-1:0] en_q;
  logic           pick_found;
  logic [IW-1:0]  pick_idx;
  logic           finish;
  logic           auto_clr;

  drq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(drq_async), .d_sync(drq_s)
  );

  assign finish   = (state_q == ST_BUSY) && xfer_done;
  assign auto_clr = finish && xfer_tc && tc_stop;

  chan_enable #(.NCH(NCH)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(en_we), .wr_data(en_wdata),
    .clr_en(auto_clr), .clr_idx(grant_q), .en_q(en_q)
  );

  assign start = !rot_mode ? '0 :
                 (last_q == IW'(NCH - 1)) ? '0 : last_q + 1'b1;

  prio_pick #(.NCH(NCH)) u_pick (
    .req(drq_s & en_q), .start(start), .found(pick_found), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      last_q  <= IW'(NCH - 1);
    end else begin
      unique case (state_q)
        ST_IDLE: if (pick_found) begin
          grant_q <= pick_idx;
          state_q <= ST_OFFER;
        end
        ST_OFFER: if (gnt_ready) state_q <= ST_BUSY;
        ST_BUSY: if (xfer_done) begin
          last_q  <= grant_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_valid  = (state_q == ST_OFFER);
  assign xfer_busy  = (state_q == ST_BUSY);
  assign gnt_idx    = grant_q;
  assign gnt_onehot = (state_q == ST_IDLE) ? '0 : (NCH'(1) << grant_q);
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           gnt_valid,
  input logic           gnt_ready,
  input logic [IW-1:0]  gnt_idx,
  input logic [NCH-1:0] gnt_onehot,
  input logic           xfer_busy,
  input logic           xfer_done,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] drq_s
);
  a_r11_onehot_active: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid || xfer_busy) |-> ($onehot(gnt_onehot) && gnt_onehot[gnt_idx]));

  a_r11_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && !xfer_busy) |-> (gnt_onehot == '0));

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_idx)));

  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !xfer_done) |=> (xfer_busy && !gnt_valid && $stable(gnt_idx)));

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ready) |=> (xfer_busy && $stable(gnt_idx)));

  a_r3_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (($past(en_q) & $past(drq_s) & gnt_onehot) != '0));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_idx(gnt_idx), .gnt_onehot(gnt_onehot), .xfer_busy(xfer_busy),
  .xfer_done(xfer_done), .en_q(en_q), .drq_s(drq_s)
);

// File: tb/sim_dma_prio_arb.sv
module sim_dma_prio_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] drq_async = '0;
  logic       rot_mode = 1'b0, tc_stop = 1'b0, en_we = 1'b0;
  logic [3:0] en_wdata = '0;
  logic       gnt_valid, gnt_ready = 1'b0;
  logic [1:0] gnt_idx;
  logic [3:0] gnt_onehot;
  logic       xfer_busy, xfer_done = 1'b0, xfer_tc = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [3:0] en_m = '0;
  logic [1:0] last_m = 2'd3;

  always #4 clk = ~clk;

  dma_prio_arb u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick_m(input logic [3:0] req, input logic [3:0] en,
                                input bit rot, input logic [1:0] last);
    int s = rot ? (int'(last) + 1) % 4 : 0;
    for (int k = 0; k < 4; k++)
      if (req[(s + k) % 4] && en[(s + k) % 4]) return (s + k) % 4;
    return -1;
  endfunction

  task automatic wr_en(input logic [3:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
    en_m = v;
  endtask

  task automatic trial(input logic [3:0] req, input bit tc, input bit wr_on_done);
    int e = pick_m(req, en_m, rot_mode, last_m);
    string rq = rot_mode ? "R5" : "R4";
    drq_async = req;
    repeat (2) @(negedge clk);
    chk(gnt_valid == 1'b0, "R2", gnt_valid, 0);
    @(negedge clk);
    if (e < 0) begin
      chk(gnt_valid == 1'b0, "R3", gnt_valid, 0);
      drq_async = '0;
      repeat (3) @(negedge clk);
      return;
    end
    chk(gnt_valid == 1'b1, "R2", gnt_valid, 1);
    chk(int'(gnt_idx) == e, rq, gnt_idx, e);
    chk(gnt_onehot == 4'(1 << e), "R11", gnt_onehot, 1 << e);
    drq_async = '0;
    repeat (3) @(negedge clk);
    chk(gnt_valid && int'(gnt_idx) == e, "R7", gnt_idx, e);
    gnt_ready = 1'b1;
    @(negedge clk);
    gnt_ready = 1'b0;
    chk(xfer_busy && !gnt_valid, "R8", {xfer_busy, gnt_valid}, 2);
    repeat (2) @(negedge clk);
    chk(xfer_busy && int'(gnt_idx) == e, "R8", gnt_idx, e);
    xfer_done = 1'b1; xfer_tc = tc;
    if (wr_on_done) begin en_we = 1'b1; en_wdata = 4'hF; end
    @(negedge clk);
    xfer_done = 1'b0; xfer_tc = 1'b0; en_we = 1'b0;
    last_m = 2'(e);
    if (wr_on_done) en_m = 4'hF;
    else if (tc && tc_stop) en_m[e] = 1'b0;
    chk(!xfer_busy && !gnt_valid && gnt_onehot == '0, "R11", gnt_onehot, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!gnt_valid && !xfer_busy && gnt_onehot == '0, "R1", gnt_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R3: everything disabled after reset
    trial(4'hF, 1'b0, 1'b0);
    // R10: enable load, R4 fixed order
    wr_en(4'hF);
    for (int i = 0; i < 3; i++) trial(4'hF, 1'b0, 1'b0);
    trial(4'b1100, 1'b0, 1'b0);
    // R6: pointer updated in fixed mode (last=2), R5 rotation walk
    rot_mode = 1'b1;
    for (int i = 0; i < 5; i++) trial(4'hF, 1'b0, 1'b0);
    // R3: masked channel ignored
    wr_en(4'b0101);
    trial(4'b1010, 1'b0, 1'b0);
    trial(4'b1110, 1'b0, 1'b0);
    // R9: tc with stop clears, without stop keeps
    rot_mode = 1'b0; tc_stop = 1'b1;
    trial(4'b0001, 1'b1, 1'b0);
    trial(4'b0001, 1'b0, 1'b0);
    tc_stop = 1'b0;
    trial(4'b0100, 1'b1, 1'b0);
    trial(4'b0100, 1'b0, 1'b0);
    // R10: write beats automatic clear
    tc_stop = 1'b1;
    trial(4'b0100, 1'b1, 1'b1);
    trial(4'b0100, 1'b0, 1'b0);
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 5) == 0) wr_en(4'($urandom_range(0, 15)));
      rot_mode = 1'($urandom_range(0, 1));
      tc_stop  = 1'($urandom_range(0, 1));
      trial(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
            $urandom_range(0, 15) == 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule